// File: doc/BRIEF.md
# DMA Interrupt Status and Clear Block

This block collects the completion, error and abort events raised by a set of DMA channels and turns them into status words and interrupt lines. For every event kind it keeps two words: a raw word that records the event whenever it is allowed to happen, and an interrupt word that records it only when the channel has not masked it. Software reads the words through a small register port and clears bits by writing ones to two clear registers.

A channel can suppress its completion status entirely with a per-channel hold input (its control word's completion mask). When the hold is set, neither word records the event. It can also mask only the interrupt word through three per-channel configuration masks, one each for completion, error and abort. When only these masks are set, the raw word still records the event. Error and abort share one register: the error flags sit in the low half and the abort flags in the upper half.

Three interrupt outputs are derived from the interrupt words: one for completion, one for error or abort, and one combined line. A summary register folds all three interrupt words into one byte, one bit per channel.

Top module: `dmairq_hub`

## Requirements
- R1: After reset, all status words read zero and all three interrupt outputs are low.
- R2: A completion pulse on channel n sets bit n of the raw completion word (offset 0x14). If hold bit n is set, the pulse is ignored, and neither the raw word nor the interrupt completion word (offset 0x04) changes.
- R3: The same pulse sets bit n of the interrupt completion word only if completion mask bit n is clear. The raw word is still set when the mask is set.
- R4: An error pulse sets bit n, and an abort pulse sets bit 16+n, of the raw error/abort word (offset 0x18). The pulse sets the matching bit of the interrupt error/abort word (offset 0x0C) only if the error mask or abort mask bit n is clear.
- R5: A write to offset 0x08 clears every bit written as 1 in both completion words. Bits written as 0 keep their value.
- R6: A write to offset 0x10 clears every bit written as 1 in both error/abort words, using the same positions: error at 7:0, abort at 23:16.
- R7: When an event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: irq_tc_o is the OR of the interrupt completion word. irq_err_o is the OR of the error and abort interrupt bits. irq_any_o is the OR of the two. All three follow the words in the cycle after the event or the clear.
- R9: Offset 0x00 reads the bitwise OR of the interrupt completion bits, the interrupt error bits and the interrupt abort bits in bits 7:0. Its upper bits read zero.
- R10: Offset 0x1C reads the channel-enable inputs. The clear offsets and unmapped offsets read zero.
- R11: Writes to any offset other than 0x08 and 0x10 change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tc_evt_i | input | NUM_CH | Completion pulse per channel |
| err_evt_i | input | NUM_CH | Error pulse per channel |
| abt_evt_i | input | NUM_CH | Abort pulse per channel |
| tc_hold_i | input | NUM_CH | Per-channel suppression of completion status |
| tc_mask_i | input | NUM_CH | Per-channel completion interrupt mask |
| err_mask_i | input | NUM_CH | Per-channel error interrupt mask |
| abt_mask_i | input | NUM_CH | Per-channel abort interrupt mask |
| ch_en_i | input | NUM_CH | Channel start bits, readable at 0x1C |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| irq_tc_o | output | 1 | Completion interrupt |
| irq_err_o | output | 1 | Error/abort interrupt |
| irq_any_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with eight channels, a 32-bit data word and the abort field starting at bit 16. With these values both the top channel bit 7 and the top abort bit 23 can be reached. A stray write into the gap between the two halves, bits 15:8, must then leave the status untouched. Using the same channel counts on both the event side and the clear side lets one pulse and one clear write hit a single bit in one cycle.

// File: rtl/dmairq_pkg.sv
`timescale 1ns/1ps
package dmairq_pkg;
  localparam int unsigned REG_AW = 8;

  typedef enum logic [REG_AW-1:0] {
    OFF_SUMMARY = 8'h00,
    OFF_TC_INT  = 8'h04,
    OFF_TC_CLR  = 8'h08,
    OFF_EA_INT  = 8'h0C,
    OFF_EA_CLR  = 8'h10,
    OFF_TC_RAW  = 8'h14,
    OFF_EA_RAW  = 8'h18,
    OFF_CH_EN   = 8'h1C
  } reg_off_e;

  localparam int unsigned N_KINDS = 3;
  localparam int unsigned K_TC  = 0;
  localparam int unsigned K_ERR = 1;
  localparam int unsigned K_ABT = 2;
endpackage

// File: rtl/dmairq_flag_bank.sv
`timescale 1ns/1ps
module dmairq_flag_bank #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic [NUM_CH-1:0] gate_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] int_o
);
  logic [NUM_CH-1:0] raw_q, int_q, raw_set, int_set;

  assign raw_set = evt_i & gate_i;
  assign int_set = raw_set & ~mask_i;

  // set after clear: a same-cycle event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      int_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_i) | raw_set;
      int_q <= (int_q & ~clr_i) | int_set;
    end
  end

  assign raw_o = raw_q;
  assign int_o = int_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|raw_set) |=> ((raw_o & $past(raw_set)) == $past(raw_set)));

  a_r5_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~raw_set)) |=> ((raw_o & $past(clr_i & ~raw_set)) == '0));

  a_r3_int_within_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int_o & ~raw_o) == '0));

  a_r3_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((int_o & ~$past(int_o) & $past(mask_i)) == '0));
endmodule

// File: rtl/dmairq_regif.sv
`timescale 1ns/1ps
module dmairq_regif
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ABT_LSB = 16
) (
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] tc_int_i,
  input  logic [NUM_CH-1:0] tc_raw_i,
  input  logic [NUM_CH-1:0] err_int_i,
  input  logic [NUM_CH-1:0] err_raw_i,
  input  logic [NUM_CH-1:0] abt_int_i,
  input  logic [NUM_CH-1:0] abt_raw_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  output logic [NUM_CH-1:0] tc_clr_o,
  output logic [NUM_CH-1:0] err_clr_o,
  output logic [NUM_CH-1:0] abt_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic tc_clr_hit, ea_clr_hit;
  logic [DATA_W-1:0] ea_int_word, ea_raw_word;

  assign tc_clr_hit = we_i && (addr_i == OFF_TC_CLR);
  assign ea_clr_hit = we_i && (addr_i == OFF_EA_CLR);

  assign tc_clr_o  = tc_clr_hit ? wdata_i[NUM_CH-1:0]        : '0;
  assign err_clr_o = ea_clr_hit ? wdata_i[NUM_CH-1:0]        : '0;
  assign abt_clr_o = ea_clr_hit ? wdata_i[ABT_LSB +: NUM_CH] : '0;

  always_comb begin
    ea_int_word = '0;
    ea_raw_word = '0;
    ea_int_word[NUM_CH-1:0]        = err_int_i;
    ea_int_word[ABT_LSB +: NUM_CH] = abt_int_i;
    ea_raw_word[NUM_CH-1:0]        = err_raw_i;
    ea_raw_word[ABT_LSB +: NUM_CH] = abt_raw_i;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_SUMMARY: rdata_o[NUM_CH-1:0] = tc_int_i | err_int_i | abt_int_i;
      OFF_TC_INT:  rdata_o[NUM_CH-1:0] = tc_int_i;
      OFF_EA_INT:  rdata_o = ea_int_word;
      OFF_TC_RAW:  rdata_o[NUM_CH-1:0] = tc_raw_i;
      OFF_EA_RAW:  rdata_o = ea_raw_word;
      OFF_CH_EN:   rdata_o[NUM_CH-1:0] = ch_en_i;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dmairq_irq_gen.sv
`timescale 1ns/1ps
module dmairq_irq_gen #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] tc_int_i,
  input  logic [NUM_CH-1:0] err_int_i,
  input  logic [NUM_CH-1:0] abt_int_i,
  output logic              irq_tc_o,
  output logic              irq_err_o,
  output logic              irq_any_o
);
  assign irq_tc_o  = |tc_int_i;
  assign irq_err_o = |(err_int_i | abt_int_i);
  assign irq_any_o = irq_tc_o | irq_err_o;
endmodule

// File: rtl/dmairq_hub.sv
`timescale 1ns/1ps
module dmairq_hub
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ABT_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tc_evt_i,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [NUM_CH-1:0] abt_evt_i,
  input  logic [NUM_CH-1:0] tc_hold_i,
  input  logic [NUM_CH-1:0] tc_mask_i,
  input  logic [NUM_CH-1:0] err_mask_i,
  input  logic [NUM_CH-1:0] abt_mask_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_tc_o,
  output logic              irq_err_o,
  output logic              irq_any_o
);
  localparam int unsigned ABT_MSB = ABT_LSB + NUM_CH - 1;

  initial begin
    if (ABT_LSB < NUM_CH || ABT_MSB >= DATA_W)
      $error("abort field overlaps error field or exceeds data width");
  end

  logic [NUM_CH-1:0] evt_a  [N_KINDS];
  logic [NUM_CH-1:0] gate_a [N_KINDS];
  logic [NUM_CH-1:0] mask_a [N_KINDS];
  logic [NUM_CH-1:0] clr_a  [N_KINDS];
  logic [NUM_CH-1:0] raw_a  [N_KINDS];
  logic [NUM_CH-1:0] int_a  [N_KINDS];

  assign evt_a[K_TC]   = tc_evt_i;
  assign evt_a[K_ERR]  = err_evt_i;
  assign evt_a[K_ABT]  = abt_evt_i;
  assign gate_a[K_TC]  = ~tc_hold_i;
  assign gate_a[K_ERR] = '1;
  assign gate_a[K_ABT] = '1;
  assign mask_a[K_TC]  = tc_mask_i;
  assign mask_a[K_ERR] = err_mask_i;
  assign mask_a[K_ABT] = abt_mask_i;

  for (genvar k = 0; k < N_KINDS; k++) begin : g_bank
    dmairq_flag_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_a[k]),
      .gate_i (gate_a[k]),
      .mask_i (mask_a[k]),
      .clr_i  (clr_a[k]),
      .raw_o  (raw_a[k]),
      .int_o  (int_a[k])
    );
  end

  dmairq_regif #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ABT_LSB(ABT_LSB)) u_regif (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .tc_int_i  (int_a[K_TC]),
    .tc_raw_i  (raw_a[K_TC]),
    .err_int_i (int_a[K_ERR]),
    .err_raw_i (raw_a[K_ERR]),
    .abt_int_i (int_a[K_ABT]),
    .abt_raw_i (raw_a[K_ABT]),
    .ch_en_i   (ch_en_i),
    .tc_clr_o  (clr_a[K_TC]),
    .err_clr_o (clr_a[K_ERR]),
    .abt_clr_o (clr_a[K_ABT]),
    .rdata_o   (reg_rdata_o)
  );

  dmairq_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
    .tc_int_i  (int_a[K_TC]),
    .err_int_i (int_a[K_ERR]),
    .abt_int_i (int_a[K_ABT]),
    .irq_tc_o  (irq_tc_o),
    .irq_err_o (irq_err_o),
    .irq_any_o (irq_any_o)
  );

  // R2: no new raw completion bit without an ungated pulse
  a_r2_hold_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_a[K_TC] & ~$past(raw_a[K_TC]) & ~$past(tc_evt_i & ~tc_hold_i)) == '0));

  a_r8_tc_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_tc_o) |-> $past(|(tc_evt_i & ~tc_hold_i & ~tc_mask_i)));

  a_r8_err_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_err_o) |-> $past(|((err_evt_i & ~err_mask_i) | (abt_evt_i & ~abt_mask_i))));

  a_r11_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i != OFF_TC_CLR && reg_addr_i != OFF_EA_CLR &&
     !(|tc_evt_i) && !(|err_evt_i) && !(|abt_evt_i))
    |=> ($stable(raw_a[K_TC]) && $stable(raw_a[K_ERR]) && $stable(raw_a[K_ABT])));
endmodule

// File: tb/dmairq_hub_tb.sv
`timescale 1ns/1ps
module dmairq_hub_tb;
  localparam int unsigned NCH = 8;
  localparam int unsigned DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] tc_evt = '0, err_evt = '0, abt_evt = '0;
  logic [NCH-1:0] tc_hold = '0, tc_mask = '0, err_mask = '0, abt_mask = '0, ch_en = '0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_tc, irq_err, irq_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmairq_hub #(.NUM_CH(NCH), .DATA_W(DW), .ABT_LSB(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tc_evt_i(tc_evt), .err_evt_i(err_evt), .abt_evt_i(abt_evt),
    .tc_hold_i(tc_hold), .tc_mask_i(tc_mask), .err_mask_i(err_mask), .abt_mask_i(abt_mask),
    .ch_en_i(ch_en),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_tc_o(irq_tc), .irq_err_o(irq_err), .irq_any_o(irq_any)
  );

  task automatic chk_reg(input logic [7:0] a, input logic [DW-1:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: offset %02h read %08h expected %08h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic e_tc, input logic e_err, input logic e_any, input string tag);
    #1;
    checks++;
    if ({irq_tc, irq_err, irq_any} !== {e_tc, e_err, e_any}) begin
      errors++;
      $display("FAIL %s: irq tc/err/any %b%b%b expected %b%b%b",
               tag, irq_tc, irq_err, irq_any, e_tc, e_err, e_any);
    end
  endtask

  // one cycle of stimulus, launched at a falling edge, captured at the next rising edge
  task automatic cycle(input logic [NCH-1:0] t, input logic [NCH-1:0] e, input logic [NCH-1:0] b,
                       input logic w, input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    tc_evt = t; err_evt = e; abt_evt = b; we = w; addr = a; wdata = d;
    @(negedge clk);
    tc_evt = '0; err_evt = '0; abt_evt = '0; we = 1'b0;
  endtask

  task automatic t_reset;
    chk_reg(8'h04, 32'h0, "R1 tc int");
    chk_reg(8'h0C, 32'h0, "R1 ea int");
    chk_reg(8'h14, 32'h0, "R1 tc raw");
    chk_reg(8'h18, 32'h0, "R1 ea raw");
    chk_reg(8'h00, 32'h0, "R1 summary");
    chk_irq(1'b0, 1'b0, 1'b0, "R1 irqs");
  endtask

  task automatic t_tc_basic;
    cycle(8'h05, '0, '0, 1'b0, 8'h00, '0);
    chk_reg(8'h14, 32'h05, "R2 raw set");
    chk_reg(8'h04, 32'h05, "R3 int set");
    chk_reg(8'h00, 32'h05, "R9 summary tc");
    chk_irq(1'b1, 1'b0, 1'b1, "R8 tc irq");
  endtask

  task automatic t_tc_hold;
    tc_hold = 8'h80;
    cycle(8'h80, '0, '0, 1'b0, 8'h00, '0);
    chk_reg(8'h14, 32'h05, "R2 hold raw");
    chk_reg(8'h04, 32'h05, "R2 hold int");
    tc_hold = '0;
  endtask

  task automatic t_tc_mask;
    tc_mask = 8'h40;
    cycle(8'h40, '0, '0, 1'b0, 8'h00, '0);
    chk_reg(8'h14, 32'h45, "R3 masked raw");
    chk_reg(8'h04, 32'h05, "R3 masked int");
    tc_mask = '0;
  endtask

  task automatic t_tc_clear;
    cycle('0, '0, '0, 1'b1, 8'h08, 32'h41);
    chk_reg(8'h14, 32'h04, "R5 partial raw");
    chk_reg(8'h04, 32'h04, "R5 partial int");
    chk_irq(1'b1, 1'b0, 1'b1, "R8 tc still");
    cycle('0, '0, '0, 1'b1, 8'h08, 32'h04);
    chk_reg(8'h14, 32'h0, "R5 full raw");
    chk_irq(1'b0, 1'b0, 1'b0, "R8 tc drop");
  endtask

  task automatic t_err_abt;
    cycle('0, 8'h02, 8'h80, 1'b0, 8'h00, '0);
    chk_reg(8'h18, 32'h0080_0002, "R4 ea raw");
    chk_reg(8'h0C, 32'h0080_0002, "R4 ea int");
    chk_reg(8'h00, 32'h82, "R9 summary ea");
    chk_irq(1'b0, 1'b1, 1'b1, "R8 err irq");
    err_mask = 8'h10; abt_mask = 8'h01;
    cycle('0, 8'h10, 8'h01, 1'b0, 8'h00, '0);
    chk_reg(8'h18, 32'h0081_0012, "R4 masked raw");
    chk_reg(8'h0C, 32'h0080_0002, "R4 masked int");
    err_mask = '0; abt_mask = '0;
  endtask

  task automatic t_ea_clear;
    cycle('0, '0, '0, 1'b1, 8'h10, 32'h0080_0000);
    chk_reg(8'h18, 32'h0001_0012, "R6 abort half raw");
    chk_reg(8'h0C, 32'h0000_0002, "R6 abort half int");
    chk_irq(1'b0, 1'b1, 1'b1, "R8 err still");
    cycle('0, '0, '0, 1'b1, 8'h10, 32'h0001_0012);
    chk_reg(8'h18, 32'h0, "R6 full raw");
    chk_irq(1'b0, 1'b0, 1'b0, "R8 err drop");
  endtask

  task automatic t_set_wins;
    cycle(8'h0C, '0, '0, 1'b0, 8'h00, '0);
    cycle(8'h08, '0, '0, 1'b1, 8'h08, 32'h0C);
    chk_reg(8'h14, 32'h08, "R7 tc set wins");
    cycle('0, 8'h01, '0, 1'b1, 8'h10, 32'h01);
    chk_reg(8'h18, 32'h01, "R7 err set wins");
  endtask

  task automatic t_misc;
    ch_en = 8'hA5;
    chk_reg(8'h1C, 32'hA5, "R10 channel enable");
    chk_reg(8'h08, 32'h0, "R10 clear offset reads zero");
    chk_reg(8'h24, 32'h0, "R10 unmapped reads zero");
    cycle('0, '0, '0, 1'b1, 8'h14, 32'hFFFF_FFFF);
    cycle('0, '0, '0, 1'b1, 8'h04, 32'hFFFF_FFFF);
    cycle('0, '0, '0, 1'b1, 8'h18, 32'hFFFF_FFFF);
    chk_reg(8'h14, 32'h08, "R11 tc unchanged");
    chk_reg(8'h18, 32'h01, "R11 ea unchanged");
    cycle('0, '0, '0, 1'b1, 8'h10, 32'h0000_FF00);
    chk_reg(8'h18, 32'h01, "R11 gap bits ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tc_basic();
    t_tc_hold();
    t_tc_mask();
    t_tc_clear();
    t_err_abt();
    t_ea_clear();
    t_set_wins();
    t_misc();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule